// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block models how a parallel NOR flash reports progress and faults while an embedded word program or erase runs. A command port starts a word program, a sector erase or a whole-array erase, or leaves status mode. An internal cycle counter sets how long each operation lasts. A small register array holds the stored words. While an operation runs, a read returns a status word instead of array data. Bit 7 is a polling bit whose meaning comes from a 2-bit status configuration register. Bit 6 flips on each read. Bit 5 is a sticky failure flag, and bit 3 reports whether the programming supply is adequate.

When an operation fails, the block stays in status mode until software writes the exit command. A failure here means a locked target, the pulse-count limit being reached, an attempt to raise a stored 0 to a 1, or an inadequate supply. A whole-array erase skips locked sectors. When any sector was locked it still finishes in status mode with bit 5 set. The status configuration register has no reset, so a reset leaves it unchanged.

Top module: `flash_status_reporter`

## Requirements
- R1: With configuration 00, while a word program is busy, a read at any address returns bit 7 equal to the complement of bit 7 of the word being programmed.
- R2: With configuration 00, while a sector or whole-array erase is busy, bit 7 of any read is 0.
- R3: With configuration 01 (10 and 11 behave alike), bit 7 is 0 while busy and 1 in status mode. After a successful operation, reads return true array data.
- R4: Bit 6 is 0 when an operation is accepted. It inverts on each rising edge of `rd_en` while busy or in status mode, and holds between strobes. Once the block is back in read mode, reads return true data.
- R5: While busy, bit 5 is 0 and the status word bits other than 7, 6 and 3 are 0. In status mode, the status word bits other than 7, 6, 5 and 3 are 0.
- R6: A word program stores the old word AND the new data, so it can only clear bits. If the new data has a 1 where the stored word has a 0, the block enters status mode with bit 5 set.
- R7: A word program or sector erase whose target sector is locked changes nothing in the array. The block does not go busy and is in status mode with bit 5 set on the next cycle. The sector is the top `SECT_W` bits of the address, and `lock_mask` bit s locks sector s.
- R8: While busy, bit 3 equals the inverse of `vpp_ok`. If `vpp_ok` is low in any busy cycle, the operation writes nothing and ends in status mode with bit 3 set.
- R9: If `pulse_over` is high in any busy cycle, the operation writes nothing and ends in status mode with bit 5 set.
- R10: Status mode persists through any command other than exit (`cmd_op` 3). Exit clears bits 5 and 3 and returns to array reads. Exit in read mode has no effect.
- R11: Reset returns the array to all ones and the block to read mode, and leaves the status configuration register unchanged.
- R12: The command codes are 0 word program, 1 sector erase, 2 whole-array erase and 3 exit. `busy` stays high for exactly `PROG_CYC`, `SERASE_CYC` or `CERASE_CYC` cycles after the accepting edge. Commands that arrive while busy are ignored.
- R13: A sector erase sets every word of its sector to all ones and leaves the other sectors alone. A whole-array erase clears only the unlocked sectors, and ends in status mode with bit 5 set if any sector was locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load the status configuration register |
| cfg_din | input | 2 | New status configuration value |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | Command code (0 program, 1 sector erase, 2 whole erase, 3 exit) |
| cmd_addr | input | ADDR_W | Word address of a program or sector erase |
| cmd_data | input | DATA_W | Word to program |
| rd_en | input | 1 | Read strobe; each rising edge counts as one read |
| rd_addr | input | ADDR_W | Read address |
| lock_mask | input | 2**SECT_W | Per-sector lock flags |
| vpp_ok | input | 1 | Programming supply adequate |
| pulse_over | input | 1 | Internal pulse-count limit exceeded |
| rd_data | output | DATA_W | Array word or status word |
| busy | output | 1 | An operation is running |

## Verification
A fixed table of word programs is run on a fresh array. The table holds data words whose bit 7 is 0 and data words whose bit 7 is 1, so an inverted or missing bit 7 in the polling bit is exposed. It also reprograms one word twice: a clearing write separates AND-merging from plain overwrite, and a raising write triggers the failure path. Directed runs each inject one fault alone: a locked sector for a program, a locked sector for a sector erase, a low supply, a pulse overrun and a locked sector during a whole-array erase. Each one is matched against its own full status word, which tells bit 5 faults apart from bit 3 faults and bit 7 polarity. Three successive read strobes during an erase fix the toggle phase. Changing the configuration and then resetting shows that the polling mode survives a reset while the array data does not.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

   typedef enum logic [1:0] {
      OP_PROG   = 2'd0,
      OP_SERASE = 2'd1,
      OP_CERASE = 2'd2,
      OP_EXIT   = 2'd3
   } fsr_op_e;

   typedef enum logic [1:0] {
      ST_READ   = 2'd0,
      ST_BUSY   = 2'd1,
      ST_STATUS = 2'd2
   } fsr_state_e;

   localparam int unsigned BIT_POLL = 7;
   localparam int unsigned BIT_TOG  = 6;
   localparam int unsigned BIT_FAIL = 5;
   localparam int unsigned BIT_VPP  = 3;

endpackage

// File: rtl/fsr_op_timer.sv
module fsr_op_timer #(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] load,
   output logic             running,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= load;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign running = (cnt_q != '0);
   assign last    = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/fsr_array.sv
module fsr_array #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned SECT_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [DATA_W-1:0]        rd_word,
   input  logic [ADDR_W-1:0]        pg_addr,
   output logic [DATA_W-1:0]        pg_old,
   input  logic                     pg_en,
   input  logic [DATA_W-1:0]        pg_word,
   input  logic [(1<<SECT_W)-1:0]   er_mask
);

   localparam int unsigned DEPTH      = 1 << ADDR_W;
   localparam int unsigned SECT_WORDS = 1 << (ADDR_W - SECT_W);

   logic [DATA_W-1:0] words [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      localparam int unsigned SEC = w / SECT_WORDS;
      logic [DATA_W-1:0] q;

      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '1;
         else if (er_mask[SEC])
            q <= '1;
         else if (pg_en && (pg_addr == ADDR_W'(w)))
            q <= pg_word;
      end

      assign words[w] = q;
   end

   assign rd_word = words[rd_addr];
   assign pg_old  = words[pg_addr];

endmodule

// File: rtl/fsr_readout.sv
module fsr_readout
   import fsr_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              tog_clr,
   input  fsr_state_e        state,
   input  fsr_op_e           op,
   input  logic [1:0]        cfg,
   input  logic              poll_src,
   input  logic              vpp_ok,
   input  logic              flag_fail,
   input  logic              flag_vpp,
   input  logic [DATA_W-1:0] arr_word,
   output logic [DATA_W-1:0] rd_data
);

   logic rd_q;
   logic tog_q;
   logic rd_rise;
   logic tog_live;

   assign rd_rise  = rd_en & ~rd_q;
   assign tog_live = (state != ST_READ);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= 1'b0;
         tog_q <= 1'b0;
      end else begin
         rd_q <= rd_en;
         if (tog_clr)
            tog_q <= 1'b0;
         else if (rd_rise && tog_live)
            tog_q <= ~tog_q;
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (state)
         ST_READ: rd_data = arr_word;
         ST_BUSY: begin
            rd_data[BIT_POLL] = (cfg == 2'b00) && (op == OP_PROG) && !poll_src;
            rd_data[BIT_TOG]  = tog_q;
            rd_data[BIT_VPP]  = ~vpp_ok;
         end
         default: begin
            rd_data[BIT_POLL] = (cfg != 2'b00) || ((op == OP_PROG) && !poll_src);
            rd_data[BIT_TOG]  = tog_q;
            rd_data[BIT_FAIL] = flag_fail;
            rd_data[BIT_VPP]  = flag_vpp;
         end
      endcase
   end

endmodule

// File: rtl/flash_status_reporter.sv
module flash_status_reporter #(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned ADDR_W     = 6,
   parameter int unsigned SECT_W     = 2,
   parameter int unsigned PROG_CYC   = 8,
   parameter int unsigned SERASE_CYC = 32,
   parameter int unsigned CERASE_CYC = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_wr,
   input  logic [1:0]               cfg_din,
   input  logic                     cmd_valid,
   input  logic [1:0]               cmd_op,
   input  logic [ADDR_W-1:0]        cmd_addr,
   input  logic [DATA_W-1:0]        cmd_data,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        rd_addr,
   input  logic [(1<<SECT_W)-1:0]   lock_mask,
   input  logic                     vpp_ok,
   input  logic                     pulse_over,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     busy
);

   import fsr_pkg::*;

   localparam int unsigned NSECT   = 1 << SECT_W;
   localparam int unsigned MAX_A   = (PROG_CYC > SERASE_CYC) ? PROG_CYC : SERASE_CYC;
   localparam int unsigned MAX_CYC = (MAX_A > CERASE_CYC) ? MAX_A : CERASE_CYC;
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

   if (DATA_W < 8) begin : g_chk_data
      $error("DATA_W must hold status bit 7");
   end
   if (SECT_W == 0 || SECT_W >= ADDR_W) begin : g_chk_sect
      $error("SECT_W must be between 1 and ADDR_W-1");
   end
   if (PROG_CYC < 1 || SERASE_CYC < 1 || CERASE_CYC < 1) begin : g_chk_cyc
      $error("operation lengths must be at least one cycle");
   end

   logic [1:0]         cfg_q;
   fsr_state_e         state_q;
   fsr_op_e            op_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  data_q;
   logic               vpp_bad_q;
   logic               pls_bad_q;
   logic               flag_fail_q;
   logic               flag_vpp_q;
   logic [NSECT-1:0]   lock_snap_q;

   logic [SECT_W-1:0]  cmd_sect;
   logic [SECT_W-1:0]  sect_q;
   logic               tgt_locked;
   logic               accept;
   logic               lock_hit;
   logic               start;
   logic [CNT_W-1:0]   tmr_load;
   logic               tmr_busy;
   logic               tmr_last;
   logic               vpp_f;
   logic               pls_f;
   logic               hw_f;
   logic               ones_fail;
   logic               end_fail;
   logic               finish;
   logic               pg_en;
   logic [DATA_W-1:0]  pg_old;
   logic [DATA_W-1:0]  pg_word;
   logic [DATA_W-1:0]  arr_word;
   logic [NSECT-1:0]   er_mask;

   // status configuration: written only by cfg_wr, untouched by reset
   always_ff @(posedge clk) begin
      if (cfg_wr)
         cfg_q <= cfg_din;
   end

   assign cmd_sect   = cmd_addr[ADDR_W-1 -: SECT_W];
   assign sect_q     = addr_q[ADDR_W-1 -: SECT_W];
   assign tgt_locked = lock_mask[cmd_sect];
   assign accept     = (state_q == ST_READ) && cmd_valid && (cmd_op != OP_EXIT);
   assign lock_hit   = accept && tgt_locked &&
                       ((cmd_op == OP_PROG) || (cmd_op == OP_SERASE));
   assign start      = accept && !lock_hit;

   always_comb begin
      unique case (cmd_op)
         OP_PROG:   tmr_load = CNT_W'(PROG_CYC);
         OP_SERASE: tmr_load = CNT_W'(SERASE_CYC);
         default:   tmr_load = CNT_W'(CERASE_CYC);
      endcase
   end

   fsr_op_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .load    (tmr_load),
      .running (tmr_busy),
      .last    (tmr_last)
   );

   // faults seen in any busy cycle, including the final one
   assign vpp_f     = vpp_bad_q | ~vpp_ok;
   assign pls_f     = pls_bad_q | pulse_over;
   assign hw_f      = vpp_f | pls_f;
   assign finish    = (state_q == ST_BUSY) && tmr_last;
   assign ones_fail = |(~pg_old & data_q);
   assign pg_word   = pg_old & data_q;
   assign pg_en     = finish && (op_q == OP_PROG) && !hw_f;
   assign end_fail  = pls_f
                    | ((op_q == OP_PROG) && ones_fail)
                    | ((op_q == OP_CERASE) && (|lock_snap_q));

   for (genvar s = 0; s < NSECT; s++) begin : g_erase
      assign er_mask[s] = finish && !hw_f &&
                          (((op_q == OP_SERASE) && (sect_q == SECT_W'(s))) ||
                           ((op_q == OP_CERASE) && !lock_snap_q[s]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_READ;
         op_q        <= OP_PROG;
         addr_q      <= '0;
         data_q      <= '0;
         vpp_bad_q   <= 1'b0;
         pls_bad_q   <= 1'b0;
         flag_fail_q <= 1'b0;
         flag_vpp_q  <= 1'b0;
         lock_snap_q <= '0;
      end else begin
         unique case (state_q)
            ST_READ: begin
               if (accept) begin
                  op_q        <= fsr_op_e'(cmd_op);
                  addr_q      <= cmd_addr;
                  data_q      <= cmd_data;
                  lock_snap_q <= lock_mask;
                  vpp_bad_q   <= 1'b0;
                  pls_bad_q   <= 1'b0;
                  if (lock_hit) begin
                     flag_fail_q <= 1'b1;
                     flag_vpp_q  <= 1'b0;
                     state_q     <= ST_STATUS;
                  end else begin
                     state_q <= ST_BUSY;
                  end
               end
            end
            ST_BUSY: begin
               vpp_bad_q <= vpp_f;
               pls_bad_q <= pls_f;
               if (tmr_last) begin
                  flag_fail_q <= end_fail;
                  flag_vpp_q  <= vpp_f;
                  state_q     <= (end_fail || vpp_f) ? ST_STATUS : ST_READ;
               end
            end
            ST_STATUS: begin
               if (cmd_valid && (cmd_op == OP_EXIT)) begin
                  flag_fail_q <= 1'b0;
                  flag_vpp_q  <= 1'b0;
                  state_q     <= ST_READ;
               end
            end
            default: state_q <= ST_READ;
         endcase
      end
   end

   fsr_array #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .SECT_W (SECT_W)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (rd_addr),
      .rd_word (arr_word),
      .pg_addr (addr_q),
      .pg_old  (pg_old),
      .pg_en   (pg_en),
      .pg_word (pg_word),
      .er_mask (er_mask)
   );

   fsr_readout #(.DATA_W(DATA_W)) u_readout (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .tog_clr   (accept),
      .state     (state_q),
      .op        (op_q),
      .cfg       (cfg_q),
      .poll_src  (data_q[BIT_POLL]),
      .vpp_ok    (vpp_ok),
      .flag_fail (flag_fail_q),
      .flag_vpp  (flag_vpp_q),
      .arr_word  (arr_word),
      .rd_data   (rd_data)
   );

   assign busy = (state_q == ST_BUSY);

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
   import fsr_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              tmr_busy,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              vpp_ok,
   input logic              cmd_valid,
   input logic [1:0]        cmd_op,
   input logic [1:0]        cfg,
   input fsr_op_e           op,
   input fsr_state_e        state
);

   logic rd_prev;

   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_prev <= 1'b0;
      else
         rd_prev <= rd_en;
   end

   a_r2_erase_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (cfg == 2'b00) && (op != OP_PROG) |-> !rd_data[BIT_POLL]);

   a_r3_cfg_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (cfg != 2'b00) |-> !rd_data[BIT_POLL]);

   a_r4_tog_flips: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) && $past(rd_en && !rd_prev)
      |-> rd_data[BIT_TOG] != $past(rd_data[BIT_TOG]));

   a_r4_tog_holds: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) && !$past(rd_en && !rd_prev)
      |-> rd_data[BIT_TOG] == $past(rd_data[BIT_TOG]));

   a_r5_fail_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !rd_data[BIT_FAIL]);

   a_r8_vpp_live: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> rd_data[BIT_VPP] == !vpp_ok);

   a_r10_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STATUS) && !(cmd_valid && (cmd_op == OP_EXIT))
      |=> state == ST_STATUS);

   a_r12_timer_matches: assert property (@(posedge clk) disable iff (!rst_n)
      busy == tmr_busy);

endmodule

bind flash_status_reporter fsr_checker #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .tmr_busy  (tmr_busy),
   .rd_en     (rd_en),
   .rd_data   (rd_data),
   .vpp_ok    (vpp_ok),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .cfg       (cfg_q),
   .op        (op_q),
   .state     (state_q)
);

// File: tb/sim_flash_status_reporter.sv
module sim_flash_status_reporter;

   localparam int CLK_PERIOD = 10;
   localparam int PROG_N   = 8;
   localparam int SERASE_N = 32;
   localparam int CERASE_N = 64;
   localparam logic [1:0] C_PROG = 2'd0, C_SER = 2'd1, C_CER = 2'd2, C_EXIT = 2'd3;

   // {addr, data, expected stored word, expect failure}
   localparam logic [38:0] VECS [0:5] = '{
      {6'd1,  16'h1234, 16'h1234, 1'b0},
      {6'd1,  16'h1230, 16'h1230, 1'b0},
      {6'd1,  16'h1234, 16'h1230, 1'b1},
      {6'd20, 16'h00FF, 16'h00FF, 1'b0},
      {6'd33, 16'h8000, 16'h8000, 1'b0},
      {6'd63, 16'hA5A5, 16'hA5A5, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_din = 2'b00;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'd0;
   logic [5:0]  cmd_addr = '0;
   logic [15:0] cmd_data = '0;
   logic        rd_en = 1'b0;
   logic [5:0]  rd_addr = '0;
   logic [3:0]  lock_mask = '0;
   logic        vpp_ok = 1'b1;
   logic        pulse_over = 1'b0;
   logic [15:0] rd_data;
   logic        busy;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_status_reporter #(
      .PROG_CYC(PROG_N), .SERASE_CYC(SERASE_N), .CERASE_CYC(CERASE_N)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_din(cfg_din),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .lock_mask(lock_mask), .vpp_ok(vpp_ok),
      .pulse_over(pulse_over), .rd_data(rd_data), .busy(busy)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_done(output int n);
      n = 0;
      while (busy && n < 2000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic peek(input logic [5:0] a, output logic [15:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] v;
      int n;

      // reset with configuration 00 loaded
      cfg_wr = 1'b1; cfg_din = 2'b00;
      repeat (3) @(negedge clk);
      cfg_wr = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 busy after reset", {15'b0, busy}, 16'h0000);
      peek(6'd0, v);
      chk("R11 erased after reset", v, 16'hFFFF);

      // table of word programs
      for (int i = 0; i < 6; i++) begin
         logic [5:0]  a;
         logic [15:0] d, e;
         logic        f;
         {a, d, e, f} = VECS[i];
         issue(C_PROG, a, d);
         peek(a, v);
         chk("R1 poll bit during program", {15'b0, v[7]}, {15'b0, ~d[7]});
         wait_done(n);
         chk("R12 program length", 16'(n), 16'(PROG_N));
         if (f) begin
            peek(a, v);
            chk("R6 raise attempt flags bit 5", {15'b0, v[5]}, 16'h0001);
            issue(C_EXIT, '0, '0);
         end
         peek(a, v);
         chk("R6 stored word", v, e);
      end

      // sector erase: poll bit, toggle, clean status word
      issue(C_SER, 6'd20, '0);
      peek(6'd20, v);
      chk("R2 R5 erase status word", v, 16'h0000);
      rd_en = 1'b1; @(negedge clk);
      chk("R4 first read toggles", {15'b0, rd_data[6]}, 16'h0001);
      rd_en = 1'b0; @(negedge clk);
      rd_en = 1'b1; @(negedge clk);
      chk("R4 second read toggles", {15'b0, rd_data[6]}, 16'h0000);
      rd_en = 1'b0; @(negedge clk);
      rd_en = 1'b1; @(negedge clk);
      chk("R4 third read toggles", {15'b0, rd_data[6]}, 16'h0001);
      rd_en = 1'b0; @(negedge clk);
      wait_done(n);
      chk("R12 sector erase length", 16'(n), 16'(SERASE_N - 6));
      peek(6'd20, v);
      chk("R13 R4 erased sector reads true data", v, 16'hFFFF);
      peek(6'd1, v);
      chk("R13 other sector kept", v, 16'h1230);
      peek(6'd33, v);
      chk("R13 other sector kept", v, 16'h8000);

      // a command while busy is ignored
      issue(C_PROG, 6'd5, 16'h0F0F);
      issue(C_PROG, 6'd6, 16'h0000);
      wait_done(n);
      chk("R12 length unchanged by extra command", 16'(n), 16'(PROG_N - 2));
      peek(6'd6, v);
      chk("R12 ignored program left word", v, 16'hFFFF);
      peek(6'd5, v);
      chk("R6 accepted program", v, 16'h0F0F);

      // locked program, sticky status, exit
      lock_mask = 4'b1000;
      issue(C_PROG, 6'd63, 16'h0000);
      chk("R7 locked program not busy", {15'b0, busy}, 16'h0000);
      peek(6'd63, v);
      chk("R7 locked program status", v, 16'h00A0);
      issue(C_PROG, 6'd7, 16'h0000);
      peek(6'd7, v);
      chk("R10 command ignored in status mode", v, 16'h00A0);
      issue(C_EXIT, '0, '0);
      peek(6'd63, v);
      chk("R7 locked word unchanged", v, 16'hA5A5);
      peek(6'd7, v);
      chk("R10 ignored program left word", v, 16'hFFFF);
      issue(C_EXIT, '0, '0);
      peek(6'd63, v);
      chk("R10 exit in read mode no effect", v, 16'hA5A5);

      // locked sector erase
      issue(C_SER, 6'd48, '0);
      peek(6'd63, v);
      chk("R7 locked erase status", v, 16'h0020);
      issue(C_EXIT, '0, '0);
      peek(6'd63, v);
      chk("R7 locked sector unchanged", v, 16'hA5A5);
      lock_mask = 4'b0000;

      // supply fault
      @(negedge clk);
      vpp_ok = 1'b0;
      issue(C_PROG, 6'd8, 16'h0000);
      peek(6'd8, v);
      chk("R8 bit 3 live during busy", {15'b0, v[3]}, 16'h0001);
      wait_done(n);
      vpp_ok = 1'b1;
      peek(6'd8, v);
      chk("R8 supply fault status", v, 16'h0088);
      issue(C_EXIT, '0, '0);
      peek(6'd8, v);
      chk("R8 no write on supply fault", v, 16'hFFFF);

      // pulse-count overrun
      @(negedge clk);
      pulse_over = 1'b1;
      issue(C_PROG, 6'd9, 16'h0000);
      wait_done(n);
      pulse_over = 1'b0;
      peek(6'd9, v);
      chk("R9 pulse overrun status", v, 16'h00A0);
      issue(C_EXIT, '0, '0);
      peek(6'd9, v);
      chk("R9 no write on overrun", v, 16'hFFFF);

      // whole-array erase with one locked sector
      lock_mask = 4'b1000;
      issue(C_CER, '0, '0);
      wait_done(n);
      chk("R12 whole erase length", 16'(n), 16'(CERASE_N));
      peek(6'd1, v);
      chk("R13 whole erase with lock status", v, 16'h0020);
      issue(C_EXIT, '0, '0);
      peek(6'd1, v);
      chk("R13 unlocked sector erased", v, 16'hFFFF);
      peek(6'd5, v);
      chk("R13 unlocked sector erased", v, 16'hFFFF);
      peek(6'd63, v);
      chk("R13 locked sector skipped", v, 16'hA5A5);

      // whole-array erase with nothing locked
      lock_mask = 4'b0000;
      issue(C_CER, '0, '0);
      wait_done(n);
      peek(6'd63, v);
      chk("R13 whole erase clean finish", v, 16'hFFFF);

      // configuration survives reset, array does not
      issue(C_PROG, 6'd10, 16'h1111);
      wait_done(n);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_din = 2'b01;
      @(negedge clk);
      cfg_wr = 1'b0;
      do_reset();
      peek(6'd10, v);
      chk("R11 reset erases array", v, 16'hFFFF);
      issue(C_PROG, 6'd2, 16'h0055);
      peek(6'd2, v);
      chk("R3 R11 poll low with config 01", {15'b0, v[7]}, 16'h0000);
      wait_done(n);
      peek(6'd2, v);
      chk("R3 true data after program", v, 16'h0055);
      lock_mask = 4'b0001;
      issue(C_PROG, 6'd3, 16'h0080);
      peek(6'd3, v);
      chk("R3 status mode poll high", v, 16'h00A0);
      issue(C_EXIT, '0, '0);
      lock_mask = 4'b0000;

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule